// File: doc/BRIEF.md
# UART Bit-Rate and Receive-Idle Timer

This block paces a UART. It produces a one-cycle bit-rate enable, `baud_tick`, that the serial shift logic uses to move one bit. The enable comes from a two-stage divider: the first stage divides by the clock-divisor input and the second by the bit-divisor input plus one. An optional divide-by-8 prescaler can run ahead of both stages. A divisor of zero turns the enable off.

The block also decodes the frame-format fields of the mode word into the number of bit times in one character, `frame_bits`. It uses that number to time receive idleness. Each pulse on `rx_strobe` marks a received character and starts the timer again. When four character times of bit ticks pass with no new strobe, `rx_timeout` pulses for one cycle. The timer then stays quiet until the next strobe. The shift registers and FIFOs are outside this block.

Top module: `uart_brg_core`

## Requirements
- R1: During and right after reset, `baud_tick` and `rx_timeout` are low.
- R2: When `mode_cfg[0]` is 0 and `clk_div` is not zero, `baud_tick` pulses once every `clk_div * (bdiv + 1)` clock cycles.
- R3: When `mode_cfg[0]` is 1, the period from R2 is eight times longer.
- R4: While `clk_div` is 0, `baud_tick` stays low.
- R5: The data-length field `mode_cfg[2:1]` gives 6 data bits for value 3, 7 data bits for value 2, and 8 data bits for values 0 and 1.
- R6: The parity field `mode_cfg[5:3]` adds one parity bit for value 0 (even) and for value 1 (odd). Values 2 to 7 add no parity bit.
- R7: The stop field `mode_cfg[7:6]` gives 2 stop bits for value 2 and 1 stop bit for every other value.
- R8: `frame_bits` equals 1 start bit plus the data bits, plus the parity bit when there is one, plus the stop bits. Its range is therefore 8 to 12.
- R9: After an `rx_strobe`, `rx_timeout` goes high in the cycle after the `4 * frame_bits`-th `baud_tick` that follows the strobe cycle. It stays high for exactly one cycle.
- R10: A new `rx_strobe` before the timeout restarts the count from zero.
- R11: Once `rx_timeout` has fired, it does not fire again until a new `rx_strobe` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 8 | Mode word: prescale select, data length, parity, stop bits |
| clk_div | input | CD_W (16) | First-stage divisor; 0 disables the tick |
| bdiv | input | BD_W (8) | Second-stage divisor minus one |
| rx_strobe | input | 1 | One-cycle pulse for each received character |
| baud_tick | output | 1 | One-cycle bit-rate enable |
| frame_bits | output | 4 | Bit times per character frame |
| rx_timeout | output | 1 | One-cycle receive-idle pulse |

## Verification
A wrong divider count changes the spacing between `baud_tick` pulses. That error shows up within the second tick period after a configuration change, and the measured gap shows the wrong factor directly. A wrong frame decode shows at once on `frame_bits`. A wrong timeout count or arming flag moves the `rx_timeout` pulse by whole bit ticks, or makes it repeat or widen. Such an error shows within four character times of a strobe.

// File: rtl/uart_brg_pkg.sv
package uart_brg_pkg;
   localparam int FRAME_W   = 4;
   localparam int MAX_FRAME = 12;

   // Number of bit times in one character for a given mode word
   function automatic logic [FRAME_W-1:0] frame_len(input logic [7:0] mode);
      logic [FRAME_W-1:0] data_n;
      logic [FRAME_W-1:0] par_n;
      logic [FRAME_W-1:0] stop_n;
      unique case (mode[2:1])
         2'd3:    data_n = 4'd6;
         2'd2:    data_n = 4'd7;
         default: data_n = 4'd8;
      endcase
      par_n  = (mode[5:3] <= 3'd1) ? 4'd1 : 4'd0;
      stop_n = (mode[7:6] == 2'd2) ? 4'd2 : 4'd1;
      return 4'd1 + data_n + par_n + stop_n;
   endfunction
endpackage

// File: rtl/uart_brg_prescale.sv
module uart_brg_prescale #(
   parameter int PRE_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pre_sel,
   output logic ref_en
);
   generate
      if (PRE_LOG2 < 0) begin : g_bad
         $error("PRE_LOG2 must not be negative");
      end
      if (PRE_LOG2 == 0) begin : g_none
         assign ref_en = 1'b1;
      end else begin : g_div
         logic [PRE_LOG2-1:0] pre_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_cnt <= '0;
            else        pre_cnt <= pre_cnt + 1'b1;
         end
         assign ref_en = !pre_sel || (&pre_cnt);
      end
   endgenerate
endmodule

// File: rtl/uart_brg_divider.sv
module uart_brg_divider #(
   parameter int CD_W = 16,
   parameter int BD_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_en,
   input  logic [CD_W-1:0] clk_div,
   input  logic [BD_W-1:0] bdiv,
   output logic            baud_tick
);
   logic [CD_W-1:0] cd_cnt;
   logic [BD_W-1:0] bd_cnt;
   logic            cd_zero;
   logic            cd_hit;

   assign cd_zero = (clk_div == '0);
   assign cd_hit  = ref_en && !cd_zero && (cd_cnt >= clk_div - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cd_cnt    <= '0;
         bd_cnt    <= '0;
         baud_tick <= 1'b0;
      end else begin
         baud_tick <= cd_hit && (bd_cnt >= bdiv);
         if (cd_zero) begin
            cd_cnt <= '0;
            bd_cnt <= '0;
         end else if (ref_en) begin
            cd_cnt <= cd_hit ? '0 : cd_cnt + 1'b1;
            if (cd_hit) bd_cnt <= (bd_cnt >= bdiv) ? '0 : bd_cnt + 1'b1;
         end
      end
   end

   // R4
   cd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clk_div) == '0) |-> !baud_tick);
endmodule

// File: rtl/uart_idle_timer.sv
module uart_idle_timer
   import uart_brg_pkg::*;
#(
   parameter int TW = $clog2(4 * MAX_FRAME)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_strobe,
   input  logic               baud_tick,
   input  logic [FRAME_W-1:0] frame_bits,
   output logic               rx_timeout
);
   logic          armed;
   logic [TW-1:0] tick_cnt;
   logic [TW-1:0] limit;

   assign limit = TW'({frame_bits, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         tick_cnt   <= '0;
         rx_timeout <= 1'b0;
      end else begin
         rx_timeout <= 1'b0;
         if (rx_strobe) begin
            armed    <= 1'b1;
            tick_cnt <= '0;
         end else if (armed && baud_tick) begin
            if (tick_cnt >= limit - 1'b1) begin
               rx_timeout <= 1'b1;
               armed      <= 1'b0;
               tick_cnt   <= '0;
            end else begin
               tick_cnt <= tick_cnt + 1'b1;
            end
         end
      end
   end

   // R9
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout |=> !rx_timeout);
   // R9
   after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout |-> ($past(baud_tick) && !$past(rx_strobe)));
   // R10
   strobe_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_timeout);
endmodule

// File: rtl/uart_brg_core.sv
module uart_brg_core
   import uart_brg_pkg::*;
#(
   parameter int CD_W     = 16,
   parameter int BD_W     = 8,
   parameter int PRE_LOG2 = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         mode_cfg,
   input  logic [CD_W-1:0]    clk_div,
   input  logic [BD_W-1:0]    bdiv,
   input  logic               rx_strobe,
   output logic               baud_tick,
   output logic [FRAME_W-1:0] frame_bits,
   output logic               rx_timeout
);
   localparam int TW = $clog2(4 * MAX_FRAME);

   generate
      if (CD_W < 1 || BD_W < 1) begin : g_bad
         $error("divisor widths must be at least 1");
      end
   endgenerate

   logic ref_en;

   uart_brg_prescale #(.PRE_LOG2(PRE_LOG2)) i_pre (
      .clk(clk), .rst_n(rst_n), .pre_sel(mode_cfg[0]), .ref_en(ref_en));

   uart_brg_divider #(.CD_W(CD_W), .BD_W(BD_W)) i_div (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .clk_div(clk_div),
      .bdiv(bdiv), .baud_tick(baud_tick));

   assign frame_bits = frame_len(mode_cfg);

   uart_idle_timer #(.TW(TW)) i_tmr (
      .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .baud_tick(baud_tick),
      .frame_bits(frame_bits), .rx_timeout(rx_timeout));

   // R8
   frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_bits >= 4'd8) && (frame_bits <= 4'd12));
endmodule

// File: tb/test_uart_brg_core.sv
module test_uart_brg_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mode_cfg = 8'h20;
   logic [15:0] clk_div = 16'd2;
   logic [7:0]  bdiv = 8'd0;
   logic        rx_strobe = 1'b0;
   logic        baud_tick;
   logic [3:0]  frame_bits;
   logic        rx_timeout;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   uart_brg_core i_uart_brg_core (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .clk_div(clk_div),
      .bdiv(bdiv), .rx_strobe(rx_strobe), .baud_tick(baud_tick),
      .frame_bits(frame_bits), .rx_timeout(rx_timeout));

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: act=%0d exp=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic measure(output int per);
      int n;
      per = -1;
      for (int k = 0; k < 3; k++) begin
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!baud_tick && n < 5000);
         per = n;
      end
   endtask

   task automatic strobe;
      @(negedge clk) rx_strobe = 1'b1;
      @(negedge clk) rx_strobe = 1'b0;
   endtask

   // counts ticks after a strobe until the timeout pulse; returns -1 if none
   task automatic count_to_timeout(input int max_cyc, output int ticks, output bit prev_tick);
      int n;
      ticks = 0; prev_tick = 0;
      if (baud_tick) ticks++;
      for (int c = 0; c < max_cyc; c++) begin
         @(negedge clk);
         if (rx_timeout) return;
         prev_tick = baud_tick;
         if (baud_tick) ticks++;
      end
      ticks = -1;
   endtask

   task automatic t_reset;
      chk(!baud_tick && !rx_timeout, "R1 in reset", {baud_tick, rx_timeout}, 0);
      @(negedge clk) rst_n = 1'b1;
      chk(!baud_tick && !rx_timeout, "R1 after reset", {baud_tick, rx_timeout}, 0);
   endtask

   task automatic t_rate(input int cd, input int bd, input bit pre, input string req);
      int per;
      mode_cfg[0] = pre; clk_div = 16'(cd); bdiv = 8'(bd);
      measure(per);
      chk(per == cd * (bd + 1) * (pre ? 8 : 1), req, per, cd * (bd + 1) * (pre ? 8 : 1));
   endtask

   task automatic t_zero_cd;
      int seen = 0;
      clk_div = 16'd0; mode_cfg[0] = 1'b0;
      @(negedge clk);
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         if (baud_tick) seen++;
      end
      chk(seen == 0, "R4 zero divisor", seen, 0);
   endtask

   task automatic t_frame(input logic [7:0] m, input int exp, input string req);
      mode_cfg = m;
      #1;
      chk(frame_bits == 4'(exp), req, frame_bits, exp);
   endtask

   task automatic t_timeout(input logic [7:0] m, input int fb);
      int ticks; bit pt;
      mode_cfg = m; clk_div = 16'd2; bdiv = 8'd0;
      strobe();
      count_to_timeout(1000, ticks, pt);
      chk(ticks == 4 * fb, "R9 tick count to timeout", ticks, 4 * fb);
      chk(pt, "R9 timeout follows a tick", pt, 1);
      @(negedge clk);
      chk(!rx_timeout, "R9 one-cycle pulse", rx_timeout, 0);
   endtask

   task automatic t_no_refire;
      int seen = 0;
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         if (rx_timeout) seen++;
      end
      chk(seen == 0, "R11 no second timeout", seen, 0);
   endtask

   task automatic t_restart;
      int ticks; bit pt; int early = 0; int n = 0;
      mode_cfg = 8'h20; clk_div = 16'd2; bdiv = 8'd0;
      strobe();
      while (n < 30) begin
         @(negedge clk);
         if (baud_tick) n++;
         if (rx_timeout) early++;
      end
      strobe();
      count_to_timeout(1000, ticks, pt);
      chk(early == 0, "R10 no timeout before restart", early, 0);
      chk(ticks == 40, "R10 count restarted", ticks, 40);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_rate(3, 0, 0, "R2 cd=3 bd=0");
      t_rate(2, 2, 0, "R2 cd=2 bd=2");
      t_rate(1, 0, 0, "R2 cd=1 every cycle");
      t_rate(5, 3, 0, "R2 cd=5 bd=3");
      t_rate(2, 1, 1, "R3 prescale cd=2 bd=1");
      t_rate(1, 0, 1, "R3 prescale cd=1");
      t_zero_cd();
      t_rate(4, 0, 0, "R4 recovers after zero");
      t_frame(8'h00, 11, "R5 R6 R8 8 data even parity 1 stop");
      t_frame(8'h06, 9,  "R5 6 data bits");
      t_frame(8'h24, 9,  "R5 R6 7 data no parity");
      t_frame(8'h0E, 9,  "R6 odd parity 6 data");
      t_frame(8'h38, 10, "R6 parity code 7 none");
      t_frame(8'h88, 12, "R7 two stop bits odd parity");
      t_frame(8'hC0, 11, "R7 stop code 3 one stop");
      t_frame(8'hA6, 9,  "R7 R8 6 data two stop no parity");
      t_frame(8'h31, 10, "R8 prescale bit no effect on frame");
      t_timeout(8'h20, 10);
      t_no_refire();
      t_timeout(8'h88, 12);
      t_restart();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule